// File: doc/BRIEF.md
# Row-Buffer Miss Counting Table

This block sits inside the controller of a two-tier memory: a small, fast tier that acts as a cache in front of a large, slow tier. Each request names a row of the slow tier. It also carries a flag that says whether that access missed in the slow bank's open-row buffer. The block keeps a set-associative table of recently touched slow-tier rows. Each entry holds a saturating count of row-buffer misses, and the block returns that row's updated count one cycle later.

When a miss lifts a row's count to or past a programmable limit, the block asks for the row to be moved into the fast tier. It then drops the entry, so the same row is not requested twice. A programmable cycle timer wipes every count in one cycle at the end of each period. Only rows that miss often within a single period can qualify for a move. Rows that are absent are allocated on access, and a full set gives up its least recently used way.

Top module: `rbm_miss_table`

## Requirements
- R1: After reset the table holds no rows and `rsp_valid` and `migrate_valid` are low.
- R2: The set is chosen by the low log2(SETS) bits of `req_row`, and the remaining upper bits form the tag. A row already present returns its own stored count.
- R3: A request is answered on `rsp_valid`/`rsp_count` in the cycle after it is accepted. An access with `req_miss`=1 adds one to the row's count. An access with `req_miss`=0 leaves the count unchanged.
- R4: A count stops at 2^CNT_W-1 and never wraps. With `thresh`=0 no move request is raised.
- R5: A newly allocated entry starts at 1 if the access was a miss, and at 0 otherwise.
- R6: `migrate_valid` pulses together with the response when the access was a miss, `thresh` is non-zero and the new count is at least `thresh`. `migrate_row` then carries the requesting row.
- R7: A row that raised a move request is removed from the table, so its next access allocates it afresh.
- R8: On allocation the lowest-numbered invalid way of the set is used. If the set is full, the least recently used way is replaced and its count is lost.
- R9: Every hit or allocation makes the accessed way the most recently used of its set.
- R10: With `period`=P>0, all counts are zeroed once every P cycles. The first clear falls on the P-th cycle after reset. Entries and their recency survive a clear, and `period`=0 disables clearing.
- R11: A request accepted in the same cycle as a clear sees its row's count as 0 before applying its own update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_row | input | ROW_W | Slow-tier row address |
| req_miss | input | 1 | 1 when the access missed the slow bank's row buffer |
| thresh | input | CNT_W | Move-request limit, 0 disables |
| period | input | PERIOD_W | Cycles between clears, 0 disables |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_count | output | CNT_W | Row's miss count after the update |
| migrate_valid | output | 1 | Request to cache the row in the fast tier |
| migrate_row | output | ROW_W | Row to be cached |

## Verification
The periodic clear and a request can land in the same cycle. In that case the request must build on a zeroed count rather than on the stored one. The bench follows the timer from reset and waits for the cycle just before a clear. It then issues a row-buffer hit to a row whose stored count is non-zero, and it expects a response of 0 rather than the old value. Random traffic with short periods hits the same coincidence many times. A bench model applies the clear before the request and judges every response.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
   // outcome of a set lookup
   typedef enum logic [1:0] {
      LK_IDLE  = 2'd0,
      LK_HIT   = 2'd1,
      LK_FREE  = 2'd2,
      LK_EVICT = 2'd3
   } lookup_kind_e;
endpackage

// File: rtl/rbm_clear_timer.sv
module rbm_clear_timer #(
   parameter int PERIOD_W = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PERIOD_W-1:0] period,
   output logic                tick
);
   logic [PERIOD_W-1:0] tmr_q;
   logic                enabled;

   assign enabled = (period != '0);
   assign tick    = enabled && (tmr_q >= period - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr_q <= '0;
      end else if (tick || !enabled) begin
         tmr_q <= '0;
      end else begin
         tmr_q <= tmr_q + 1'b1;
      end
   end

   AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (tmr_q == '0)); // R10
   AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (period == '0) |-> !tick); // R10
endmodule

// File: rtl/rbm_way_match.sv
module rbm_way_match
   import rbm_pkg::*;
#(
   parameter int WAYS  = 16,
   parameter int TAG_W = 21,
   parameter int WAY_W = 4
) (
   input  logic                        active,
   input  logic [WAYS-1:0]             val_row,
   input  logic [WAYS-1:0][TAG_W-1:0]  tag_row,
   input  logic [WAYS-1:0][WAY_W-1:0]  age_row,
   input  logic [TAG_W-1:0]            req_tag,
   output logic [WAYS-1:0]             hit_vec,
   output logic [WAY_W-1:0]            sel_way,
   output lookup_kind_e                kind
);
   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

   logic [WAY_W-1:0] hit_way, free_way, lru_way;
   logic             any_hit, any_free;

   genvar g;
   generate
      for (g = 0; g < WAYS; g++) begin : g_cmp
         assign hit_vec[g] = val_row[g] && (tag_row[g] == req_tag);
      end
   endgenerate

   always_comb begin
      hit_way  = '0;
      free_way = '0;
      lru_way  = '0;
      any_hit  = 1'b0;
      any_free = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) begin
            hit_way = WAY_W'(w);
            any_hit = 1'b1;
         end
         if (age_row[w] == OLDEST) lru_way = WAY_W'(w);
      end
      // lowest-numbered invalid way wins
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!val_row[w]) begin
            free_way = WAY_W'(w);
            any_free = 1'b1;
         end
      end
   end

   always_comb begin
      if (!active) begin
         kind    = LK_IDLE;
         sel_way = hit_way;
      end else if (any_hit) begin
         kind    = LK_HIT;
         sel_way = hit_way;
      end else if (any_free) begin
         kind    = LK_FREE;
         sel_way = free_way;
      end else begin
         kind    = LK_EVICT;
         sel_way = lru_way;
      end
   end
endmodule

// File: rtl/rbm_lru_touch.sv
module rbm_lru_touch #(
   parameter int WAYS  = 16,
   parameter int WAY_W = 4
) (
   input  logic [WAYS-1:0][WAY_W-1:0] ages_in,
   input  logic [WAY_W-1:0]           way,
   output logic [WAYS-1:0][WAY_W-1:0] ages_out
);
   logic [WAY_W-1:0] pivot;
   assign pivot = ages_in[way];

   genvar g;
   generate
      for (g = 0; g < WAYS; g++) begin : g_age
         always_comb begin
            if (way == WAY_W'(g))          ages_out[g] = '0;
            else if (ages_in[g] < pivot)   ages_out[g] = ages_in[g] + 1'b1;
            else                           ages_out[g] = ages_in[g];
         end
      end
   endgenerate
endmodule

// File: rtl/rbm_count_update.sv
module rbm_count_update #(
   parameter int CNT_W = 6
) (
   input  logic [CNT_W-1:0] old_cnt,
   input  logic             is_hit,
   input  logic             clr,
   input  logic             miss,
   input  logic [CNT_W-1:0] thresh,
   output logic [CNT_W-1:0] new_cnt,
   output logic             fire
);
   localparam logic [CNT_W-1:0] CMAX = '1;
   logic [CNT_W-1:0] base;

   always_comb begin
      base = (is_hit && !clr) ? old_cnt : '0;
      if (miss && (base != CMAX)) new_cnt = base + 1'b1;
      else                        new_cnt = base;
      fire = miss && (thresh != '0) && (new_cnt >= thresh);
   end
endmodule

// File: rtl/rbm_miss_table.sv
module rbm_miss_table
   import rbm_pkg::*;
#(
   parameter int SETS     = 128,
   parameter int WAYS     = 16,
   parameter int ROW_W    = 28,
   parameter int CNT_W    = 6,
   parameter int PERIOD_W = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [ROW_W-1:0]    req_row,
   input  logic                req_miss,
   input  logic [CNT_W-1:0]    thresh,
   input  logic [PERIOD_W-1:0] period,
   output logic                rsp_valid,
   output logic [CNT_W-1:0]    rsp_count,
   output logic                migrate_valid,
   output logic [ROW_W-1:0]    migrate_row
);
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = ROW_W - SET_W;
   localparam logic [CNT_W-1:0] CMAX = '1;

   generate
      if ((1 << SET_W) != SETS || SETS < 2)
         $error("SETS must be a power of two, at least 2");
      if ((1 << WAY_W) != WAYS || WAYS < 2)
         $error("WAYS must be a power of two, at least 2");
      if (TAG_W < 1)
         $error("ROW_W must exceed the set index width");
      if (CNT_W < 2 || PERIOD_W < 2)
         $error("CNT_W and PERIOD_W must be at least 2");
   endgenerate

   // table storage
   logic [WAYS-1:0]            val_q [SETS];
   logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
   logic [WAYS-1:0][CNT_W-1:0] cnt_q [SETS];
   logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];

   logic [SET_W-1:0]           set_idx;
   logic [TAG_W-1:0]           req_tag;
   logic [WAYS-1:0]            hit_vec;
   logic [WAY_W-1:0]           sel_way;
   lookup_kind_e               kind;
   logic                       is_hit;
   logic [CNT_W-1:0]           cnt_rd;
   logic [CNT_W-1:0]           new_cnt;
   logic                       fire;
   logic                       clr_tick;
   logic [WAYS-1:0][WAY_W-1:0] ages_next;

   assign set_idx = req_row[SET_W-1:0];
   assign req_tag = req_row[ROW_W-1:SET_W];
   assign cnt_rd  = cnt_q[set_idx][sel_way];
   assign is_hit  = (kind == LK_HIT);

   rbm_clear_timer #(.PERIOD_W(PERIOD_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .period (period),
      .tick   (clr_tick)
   );

   rbm_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
      .active  (req_valid),
      .val_row (val_q[set_idx]),
      .tag_row (tag_q[set_idx]),
      .age_row (age_q[set_idx]),
      .req_tag (req_tag),
      .hit_vec (hit_vec),
      .sel_way (sel_way),
      .kind    (kind)
   );

   rbm_count_update #(.CNT_W(CNT_W)) u_count (
      .old_cnt (cnt_rd),
      .is_hit  (is_hit),
      .clr     (clr_tick),
      .miss    (req_miss),
      .thresh  (thresh),
      .new_cnt (new_cnt),
      .fire    (fire)
   );

   rbm_lru_touch #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
      .ages_in  (age_q[set_idx]),
      .way      (sel_way),
      .ages_out (ages_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            val_q[s] <= '0;
            tag_q[s] <= '0;
            cnt_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
         end
      end else begin
         if (clr_tick) begin
            for (int s = 0; s < SETS; s++) cnt_q[s] <= '0;
         end
         if (kind != LK_IDLE) begin
            val_q[set_idx][sel_way] <= !fire;
            tag_q[set_idx][sel_way] <= req_tag;
            cnt_q[set_idx][sel_way] <= new_cnt;
            age_q[set_idx]          <= ages_next;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_count     <= '0;
         migrate_valid <= 1'b0;
         migrate_row   <= '0;
      end else begin
         rsp_valid     <= req_valid;
         migrate_valid <= req_valid && fire;
         if (req_valid) begin
            rsp_count   <= new_cnt;
            migrate_row <= req_row;
         end
      end
   end

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R3
   AST_HIT_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_hit && !req_miss && !clr_tick) |=> (rsp_count == $past(cnt_rd))); // R3
   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $onehot0(hit_vec)); // R2
   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_hit && !clr_tick && cnt_rd == CMAX) |=> (rsp_count == CMAX)); // R4
   AST_FILL_START: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !is_hit) |=> (rsp_count <= CNT_W'(1))); // R5
   AST_MIG_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      migrate_valid |-> ($past(req_miss) && rsp_valid)); // R6
   AST_MIG_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
      migrate_valid |-> ($past(thresh) != '0 && rsp_count >= $past(thresh))); // R6
   AST_CLEAR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && clr_tick) |=> (rsp_count <= CNT_W'(1))); // R11
endmodule

// File: tb/sim_rbm_miss_table.sv
module sim_rbm_miss_table;
   localparam int S    = 4;
   localparam int W    = 4;
   localparam int RW   = 8;
   localparam int CW   = 4;
   localparam int PW   = 8;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [RW-1:0] req_row = '0;
   logic          req_miss = 1'b0;
   logic [CW-1:0] thresh = '0;
   logic [PW-1:0] period = '0;
   logic          rsp_valid;
   logic [CW-1:0] rsp_count;
   logic          migrate_valid;
   logic [RW-1:0] migrate_row;

   always #4 clk = ~clk;

   rbm_miss_table #(.SETS(S), .WAYS(W), .ROW_W(RW), .CNT_W(CW), .PERIOD_W(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
      .req_miss(req_miss), .thresh(thresh), .period(period),
      .rsp_valid(rsp_valid), .rsp_count(rsp_count),
      .migrate_valid(migrate_valid), .migrate_row(migrate_row));

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_tag = "R1";
   bit    chk_en = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model built from the requirements
   int m_val [S][W];
   int m_tag [S][W];
   int m_cnt [S][W];
   int m_age [S][W];
   int m_tmr;
   int exp_rv, exp_cnt, exp_mv, exp_row;
   int ms, mt, hw, av, c;
   bit tk, fire;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < S; s++)
            for (int w = 0; w < W; w++) begin
               m_val[s][w] = 0; m_tag[s][w] = 0; m_cnt[s][w] = 0; m_age[s][w] = w;
            end
         m_tmr = 0; exp_rv = 0; exp_mv = 0; exp_cnt = 0; exp_row = 0;
      end else begin
         tk = (period != 0) && (m_tmr >= int'(period) - 1);
         m_tmr = tk ? 0 : ((period != 0) ? m_tmr + 1 : 0);
         if (tk)
            for (int s = 0; s < S; s++)
               for (int w = 0; w < W; w++) m_cnt[s][w] = 0;
         exp_rv = int'(req_valid);
         exp_mv = 0;
         if (req_valid) begin
            ms = int'(req_row) % S;
            mt = int'(req_row) / S;
            hw = -1;
            for (int w = 0; w < W; w++)
               if (m_val[ms][w] != 0 && m_tag[ms][w] == mt) hw = w;
            if (hw >= 0) c = m_cnt[ms][hw];
            else begin
               c = 0;
               for (int w = W - 1; w >= 0; w--) if (m_val[ms][w] == 0) hw = w;
               if (hw < 0)
                  for (int w = 0; w < W; w++) if (m_age[ms][w] == W - 1) hw = w;
            end
            if (req_miss && c < CMAX) c++;
            fire = req_miss && thresh != 0 && c >= int'(thresh);
            m_val[ms][hw] = fire ? 0 : 1;
            m_tag[ms][hw] = mt;
            m_cnt[ms][hw] = c;
            av = m_age[ms][hw];
            for (int w = 0; w < W; w++)
               if (w == hw) m_age[ms][w] = 0;
               else if (m_age[ms][w] < av) m_age[ms][w]++;
            exp_cnt = c; exp_mv = int'(fire); exp_row = int'(req_row);
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && chk_en) begin
         chk({cur_tag, " rsp_valid"}, int'(rsp_valid), exp_rv);
         if (exp_rv != 0) begin
            chk({cur_tag, " count"}, int'(rsp_count), exp_cnt);
            chk({cur_tag, " R6 migrate_valid"}, int'(migrate_valid), exp_mv);
            if (exp_mv != 0) chk({cur_tag, " R6 migrate_row"}, int'(migrate_row), exp_row);
         end
      end
   end

   task automatic send(input int r, input bit m);
      req_valid = 1'b1; req_row = RW'(r); req_miss = m;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      req_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle after reset
      chk("R1 rsp_valid", int'(rsp_valid), 0);
      chk("R1 migrate_valid", int'(migrate_valid), 0);
      chk_en = 1'b1;

      // R5 / R3 / R2 on row 0x31 (set 1)
      cur_tag = "R5";
      send(8'h31, 1'b0); chk("R5 fill on hit", int'(rsp_count), 0);
      cur_tag = "R3";
      send(8'h31, 1'b1); chk("R3 miss adds", int'(rsp_count), 1);
      send(8'h31, 1'b0); chk("R3 hit keeps", int'(rsp_count), 1);
      cur_tag = "R2";
      send(8'h35, 1'b1); chk("R2 other tag same set", int'(rsp_count), 1);
      send(8'h31, 1'b1); chk("R2 own count", int'(rsp_count), 2);

      // R4: saturation with move requests disabled
      cur_tag = "R4";
      thresh = '0;
      for (int i = 0; i < CMAX + 4; i++) send(8'h22, 1'b1);
      chk("R4 saturated", int'(rsp_count), CMAX);
      chk("R4 no move at thresh 0", int'(migrate_valid), 0);

      // R6 / R7
      cur_tag = "R6";
      thresh = 4'd3;
      send(8'h23, 1'b1); send(8'h23, 1'b1);
      chk("R6 below limit", int'(migrate_valid), 0);
      send(8'h23, 1'b1);
      chk("R6 reached", int'(migrate_valid), 1);
      chk("R6 row", int'(migrate_row), 8'h23);
      chk("R6 count", int'(rsp_count), 3);
      cur_tag = "R7";
      send(8'h23, 1'b1);
      chk("R7 reallocated", int'(rsp_count), 1);
      chk("R7 no repeat", int'(migrate_valid), 0);
      thresh = '0;

      // R8 / R9 in set 0
      cur_tag = "R8";
      send(8'h04, 1'b1); send(8'h08, 1'b1); send(8'h0C, 1'b1); send(8'h10, 1'b1);
      cur_tag = "R9";
      send(8'h04, 1'b1); chk("R9 hit refresh", int'(rsp_count), 2);
      cur_tag = "R8";
      send(8'h14, 1'b1); chk("R8 new row", int'(rsp_count), 1);
      send(8'h04, 1'b0); chk("R9 recent row kept", int'(rsp_count), 2);
      send(8'h08, 1'b0); chk("R8 lru evicted", int'(rsp_count), 0);

      // R10: counts wiped after a period, entries kept
      cur_tag = "R10";
      idle(2);
      period = 8'd20;
      idle(45);
      send(8'h04, 1'b0); chk("R10 cleared kept entry", int'(rsp_count), 0);
      send(8'h04, 1'b1); chk("R10 counts again", int'(rsp_count), 1);

      // R11: request in the clear cycle
      cur_tag = "R11";
      send(8'h04, 1'b1);
      req_valid = 1'b0;
      while (m_tmr != int'(period) - 1) @(negedge clk);
      send(8'h04, 1'b0); chk("R11 clear wins", int'(rsp_count), 0);
      req_valid = 1'b0;
      while (m_tmr != int'(period) - 1) @(negedge clk);
      send(8'h04, 1'b1); chk("R11 clear then miss", int'(rsp_count), 1);

      // constrained random traffic
      cur_tag = "R3 R6 R8 R10 random";
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 200 == 0) thresh = CW'($urandom % 6);
         if ($urandom % 500 == 0) period = ($urandom % 3 == 0) ? '0 : PW'(23 + $urandom % 40);
         if ($urandom % 8 == 0) idle(1 + $urandom % 3);
         send(int'($urandom % 48), ($urandom % 3) != 0);
      end
      idle(3);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule